// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block turns internal read and write requests into cycles on a shared 16-bit address/data bus. Each request carries an address, write data, a low-byte/high-byte enable pair, the bus width (8 or 16 bits) and the choice of write-strobe function. Every external cycle lasts four state times, paced by a state-time tick from outside the block: an address state with ALE high, an address-hold state with ALE low, a strobe state with RD# or the write strobe low, and a recovery state. In the recovery state write data stays on the bus and ADV# is already high again. The requester holds its request until a one-clock `rsp_done` pulse, which also carries the read data.

An access-select strap is sampled while reset is held. Together with the address, it decides whether a request runs on the bus or goes to internal storage. Internal requests finish at once with `rsp_internal` set and cause no bus activity. In 8-bit mode a word request becomes two byte cycles, even address first. Only the low lanes carry data, and the upper lanes keep address bits 15:8.

States: IDLE (bus quiet), ADDR (ALE high, address driven), ALAT (ALE low, address held), XFER (strobe low), RCVR (write data held, ADV# high). Transitions, each taken on a tick: IDLE to ADDR on an accepted external request; ADDR to ALAT; ALAT to XFER; XFER to RCVR; RCVR to ADDR for the second half of a split word or for a new external request; RCVR to IDLE otherwise. An internal request is answered in IDLE on a tick.

Top module: `xbus_ctrl`

## Requirements
- R1: ALE is high for exactly the first state time of each external cycle. The address is driven on `ad_out` with `ad_oe` high during that state time and during the next one, and it stays unchanged when ALE falls. No strobe is low while ALE is high.
- R2: ADV# is low from the ALE state through the strobe state. It is high in the recovery state and in idle, so it is high whenever `rsp_done` pulses.
- R3: RD# goes low only in the strobe state of a read, with `ad_oe` low. Read data is sampled from `ad_in` at the end of that state. In 16-bit mode all 16 bits are returned.
- R4: The write strobe goes low only in the strobe state of a write, never together with RD#. With `cfg_strobe_sel`=1 it acts as WR# and goes low for every write. With `cfg_strobe_sel`=0 it acts as WRL#: in 16-bit mode it goes low only when `req_be[0]`=1 (bit 0 enables the low byte, bit 1 the high byte), and in 8-bit mode it goes low for every write.
- R5: Write data stays on `ad_out` with `ad_oe` high for the whole strobe and for one state time after the strobe rises.
- R6: In 8-bit mode data moves on `ad[7:0]` and `ad[15:8]` keeps address bits 15:8 during the data phase. `req_be`=2'b11 runs two cycles, at the even address and then at the odd address, with one `rsp_done`. `req_be`=2'b10 runs one cycle at the odd address using `wdata[15:8]`, and read bytes return in `rsp_rdata[15:8]`.
- R7: Back-to-back external cycles, whether from a split word or from a request presented right after `rsp_done`, have ALE rises exactly four state times apart.
- R8: The strap `ea_n` is sampled while `rst_n` is low and the last value before release is held. Later changes of `ea_n` do not affect routing.
- R9: Addresses 0000h-02FFh and 1F00h-1FFBh are always internal. Addresses 0300h-1EFFh and 8000h-FFFFh are always external. Addresses 1FFCh-1FFFh and 2000h-7FFFh are internal when the held strap is high and external when it is low. An internal request gets `rsp_done` with `rsp_internal`=1 and no bus activity.
- R10: After reset ALE is 0, ADV#, RD# and the write strobe are 1, `ad_oe` is 0 and `rsp_done` is 0. `rsp_done` is a one-clock pulse at the end of the last strobe state time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; strap sampled while low |
| st_tick | input | 1 | One-clock pulse marking the end of each state time |
| ea_n | input | 1 | Access-select strap, low selects external routing |
| cfg_strobe_sel | input | 1 | 1: write pin acts as WR#, 0: as WRL# |
| cfg_bus16 | input | 1 | 1: 16-bit bus, 0: 8-bit bus |
| req_valid | input | 1 | Request present, held until rsp_done |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 16 | Byte address |
| req_be | input | 2 | Byte enables, bit 0 low byte, bit 1 high byte |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_internal | output | 1 | With rsp_done: request was routed internally |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| ad_in | input | 16 | Bus value seen on the pads |
| ad_out | output | 16 | Value driven onto the bus |
| ad_oe | output | 1 | Bus output enable |
| ale | output | 1 | Address latch enable, active high |
| adv_n | output | 1 | Address valid, active low |
| rd_n | output | 1 | Read strobe, active low |
| wrx_n | output | 1 | Write strobe (WR# or WRL#), active low |

## Verification
The bench keeps the default address-partition parameters and drives `st_tick` every third clock. With that setting, a one-clock lag or an early strobe shows up as a wrong gap between ALE rises. It also lets the recovery state span several clocks, so a new request presented just after `rsp_done` tests the back-to-back path. The bench models the bus slave as the latched address XOR a constant, which makes every byte lane and every half of a split word separately identifiable.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int XB_AW    = 16;
    localparam int XB_DW    = 16;
    localparam int XB_LANES = XB_DW / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ALAT,
        ST_XFER,
        ST_RCVR
    } xb_state_e;

    // request fields held for the duration of a bus cycle
    typedef struct packed {
        logic             wr;
        logic             b16;
        logic             wsel;
        logic             lo_en;
        logic [XB_AW-1:0] addr;
        logic [XB_DW-1:0] wdata;
    } xb_req_t;

endpackage

// File: rtl/xbus_route.sv
module xbus_route
    import xbus_pkg::*;
#(
    parameter logic [XB_AW-1:0] RAM_TOP   = 16'h02FF,
    parameter logic [XB_AW-1:0] SFR_BASE  = 16'h1F00,
    parameter logic [XB_AW-1:0] PORT_BASE = 16'h1FFC,
    parameter logic [XB_AW-1:0] PORT_TOP  = 16'h1FFF,
    parameter logic [XB_AW-1:0] PROG_BASE = 16'h2000,
    parameter logic [XB_AW-1:0] PROG_TOP  = 16'h7FFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ea_n,
    input  logic [XB_AW-1:0] addr,
    output logic             ea_act,
    output logic             to_ext
);

    logic in_ram;
    logic in_sfr;
    logic in_port;
    logic in_prog;

    // strap follows the pin only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_act <= ~ea_n;
        end
    end

    always_comb begin
        in_ram  = (addr <= RAM_TOP);
        in_sfr  = (addr >= SFR_BASE)  && (addr < PORT_BASE);
        in_port = (addr >= PORT_BASE) && (addr <= PORT_TOP);
        in_prog = (addr >= PROG_BASE) && (addr <= PROG_TOP);
        to_ext  = !(in_ram || in_sfr || ((in_port || in_prog) && !ea_act));
    end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             st_tick,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [XB_AW-1:0] req_addr,
    input  logic [1:0]       req_be,
    input  logic [XB_DW-1:0] req_wdata,
    input  logic             cfg_bus16,
    input  logic             cfg_strobe_sel,
    input  logic             to_ext,
    input  logic [XB_DW-1:0] ad_in,
    output xb_state_e        state_q,
    output xb_req_t          cur_q,
    output logic             half_q,
    output logic [XB_AW-1:0] cyc_addr,
    output logic             rsp_done,
    output logic             rsp_internal,
    output logic [XB_DW-1:0] rsp_rdata
);

    xb_state_e state_d;
    logic      split_q;
    logic      more_now;
    logic      can_take;
    logic      accept;
    logic      int_take;

    assign more_now = split_q && !half_q;
    assign can_take = st_tick && req_valid && !rsp_done;
    assign accept   = can_take && to_ext &&
                      ((state_q == ST_IDLE) || ((state_q == ST_RCVR) && !more_now));
    assign int_take = can_take && !to_ext && (state_q == ST_IDLE);
    assign cyc_addr = cur_q.b16 ? cur_q.addr : {cur_q.addr[XB_AW-1:1], half_q};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)  state_d = ST_ADDR;
            ST_ADDR: if (st_tick) state_d = ST_ALAT;
            ST_ALAT: if (st_tick) state_d = ST_XFER;
            ST_XFER: if (st_tick) state_d = ST_RCVR;
            ST_RCVR: begin
                if (st_tick) begin
                    state_d = (more_now || accept) ? ST_ADDR : ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q        <= '0;
            half_q       <= 1'b0;
            split_q      <= 1'b0;
            rsp_done     <= 1'b0;
            rsp_internal <= 1'b0;
            rsp_rdata    <= '0;
        end else begin
            rsp_done     <= 1'b0;
            rsp_internal <= 1'b0;
            if (accept) begin
                cur_q.wr    <= req_write;
                cur_q.b16   <= cfg_bus16;
                cur_q.wsel  <= cfg_strobe_sel;
                cur_q.lo_en <= req_be[0];
                cur_q.addr  <= req_addr;
                cur_q.wdata <= req_wdata;
                half_q      <= !cfg_bus16 && (req_be == 2'b10);
                split_q     <= !cfg_bus16 && (req_be == 2'b11);
                rsp_rdata   <= '0;
            end else if ((state_q == ST_RCVR) && st_tick && more_now) begin
                half_q <= 1'b1;
            end
            if (int_take) begin
                rsp_done     <= 1'b1;
                rsp_internal <= 1'b1;
            end
            if ((state_q == ST_XFER) && st_tick) begin
                if (!cur_q.wr) begin
                    if (cur_q.b16) begin
                        rsp_rdata <= ad_in;
                    end else if (half_q) begin
                        rsp_rdata[15:8] <= ad_in[7:0];
                    end else begin
                        rsp_rdata[7:0] <= ad_in[7:0];
                    end
                end
                if (!more_now) begin
                    rsp_done <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
    import xbus_pkg::*;
(
    input  xb_state_e        state_q,
    input  xb_req_t          cur_q,
    input  logic             half_q,
    input  logic [XB_AW-1:0] cyc_addr,
    output logic [XB_DW-1:0] ad_out,
    output logic             ad_oe,
    output logic             ale,
    output logic             adv_n,
    output logic             rd_n,
    output logic             wrx_n
);

    logic [XB_DW-1:0] data_word;
    logic             lane_ok;

    // lane 0 carries the selected byte in 8-bit mode; upper lanes keep address
    for (genvar g = 0; g < XB_LANES; g++) begin : g_lane
        if (g == 0) begin : g_low
            assign data_word[7:0] = cur_q.b16 ? cur_q.wdata[7:0] :
                                    (half_q ? cur_q.wdata[15:8] : cur_q.wdata[7:0]);
        end else begin : g_up
            assign data_word[g*8 +: 8] = cur_q.b16 ? cur_q.wdata[g*8 +: 8]
                                                   : cyc_addr[g*8 +: 8];
        end
    end

    assign lane_ok = cur_q.wsel || !cur_q.b16 || cur_q.lo_en;

    always_comb begin
        ale    = 1'b0;
        adv_n  = 1'b1;
        rd_n   = 1'b1;
        wrx_n  = 1'b1;
        ad_oe  = 1'b0;
        ad_out = '0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_ADDR: begin
                ale    = 1'b1;
                adv_n  = 1'b0;
                ad_oe  = 1'b1;
                ad_out = cyc_addr;
            end
            ST_ALAT: begin
                adv_n  = 1'b0;
                ad_oe  = 1'b1;
                ad_out = cyc_addr;
            end
            ST_XFER: begin
                adv_n = 1'b0;
                if (cur_q.wr) begin
                    ad_oe  = 1'b1;
                    ad_out = data_word;
                    wrx_n  = !lane_ok;
                end else begin
                    rd_n = 1'b0;
                end
            end
            ST_RCVR: begin
                if (cur_q.wr) begin
                    ad_oe  = 1'b1;
                    ad_out = data_word;
                end
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter logic [XB_AW-1:0] RAM_TOP   = 16'h02FF,
    parameter logic [XB_AW-1:0] SFR_BASE  = 16'h1F00,
    parameter logic [XB_AW-1:0] PORT_BASE = 16'h1FFC,
    parameter logic [XB_AW-1:0] PORT_TOP  = 16'h1FFF,
    parameter logic [XB_AW-1:0] PROG_BASE = 16'h2000,
    parameter logic [XB_AW-1:0] PROG_TOP  = 16'h7FFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             st_tick,
    input  logic             ea_n,
    input  logic             cfg_strobe_sel,
    input  logic             cfg_bus16,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [XB_AW-1:0] req_addr,
    input  logic [1:0]       req_be,
    input  logic [XB_DW-1:0] req_wdata,
    output logic             rsp_done,
    output logic             rsp_internal,
    output logic [XB_DW-1:0] rsp_rdata,
    input  logic [XB_DW-1:0] ad_in,
    output logic [XB_DW-1:0] ad_out,
    output logic             ad_oe,
    output logic             ale,
    output logic             adv_n,
    output logic             rd_n,
    output logic             wrx_n
);

    logic             ea_act;
    logic             to_ext;
    xb_state_e        state_q;
    xb_req_t          cur_q;
    logic             half_q;
    logic [XB_AW-1:0] cyc_addr;

    xbus_route #(
        .RAM_TOP  (RAM_TOP),
        .SFR_BASE (SFR_BASE),
        .PORT_BASE(PORT_BASE),
        .PORT_TOP (PORT_TOP),
        .PROG_BASE(PROG_BASE),
        .PROG_TOP (PROG_TOP)
    ) u_route (
        .clk   (clk),
        .rst_n (rst_n),
        .ea_n  (ea_n),
        .addr  (req_addr),
        .ea_act(ea_act),
        .to_ext(to_ext)
    );

    xbus_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .st_tick       (st_tick),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_be        (req_be),
        .req_wdata     (req_wdata),
        .cfg_bus16     (cfg_bus16),
        .cfg_strobe_sel(cfg_strobe_sel),
        .to_ext        (to_ext),
        .ad_in         (ad_in),
        .state_q       (state_q),
        .cur_q         (cur_q),
        .half_q        (half_q),
        .cyc_addr      (cyc_addr),
        .rsp_done      (rsp_done),
        .rsp_internal  (rsp_internal),
        .rsp_rdata     (rsp_rdata)
    );

    xbus_pins u_pins (
        .state_q (state_q),
        .cur_q   (cur_q),
        .half_q  (half_q),
        .cyc_addr(cyc_addr),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe),
        .ale     (ale),
        .adv_n   (adv_n),
        .rd_n    (rd_n),
        .wrx_n   (wrx_n)
    );

endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ale,
    input logic        adv_n,
    input logic        rd_n,
    input logic        wrx_n,
    input logic        ad_oe,
    input logic [15:0] ad_out,
    input logic        rsp_done,
    input logic        ea_act
);

    a_r1_addr_held_at_ale_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> ad_oe && $stable(ad_out));

    a_r1_no_strobe_with_ale: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> rd_n && wrx_n && ad_oe);

    a_r2_adv_low_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (ale || !rd_n || !wrx_n) |-> !adv_n);

    a_r2_adv_high_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> adv_n);

    a_r3_read_releases_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    a_r5_data_held_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wrx_n) |-> ad_oe && $stable(ad_out));

    a_r8_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(ea_act));

    always @(posedge clk) begin
        if (rst_n) begin
            a_r4_strobes_exclusive: assert (rd_n || wrx_n);
        end
    end

endmodule

bind xbus_ctrl xbus_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ale     (ale),
    .adv_n   (adv_n),
    .rd_n    (rd_n),
    .wrx_n   (wrx_n),
    .ad_oe   (ad_oe),
    .ad_out  (ad_out),
    .rsp_done(rsp_done),
    .ea_act  (ea_act)
);

// File: tb/xbus_ctrl_tb_top.sv
module xbus_ctrl_tb_top;

    localparam int CLK_P    = 10;
    localparam int TICK_DIV = 3;
    localparam logic [15:0] KEY = 16'h5A3C;

    typedef struct packed {
        logic        wr;
        logic        b16;
        logic        ssel;
        logic [1:0]  be;
        logic [15:0] addr;
        logic [15:0] wd;
        logic [1:0]  n_ale;
        logic [1:0]  n_str;
        logic        intl;
        logic [15:0] e_addr;
        logic [15:0] e_val;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [0:NV-1] = '{
        '{1'b1,1'b1,1'b1,2'b11,16'h8000,16'hCAFE,2'd1,2'd1,1'b0,16'h8000,16'hCAFE},
        '{1'b1,1'b1,1'b0,2'b10,16'h8002,16'h1111,2'd1,2'd0,1'b0,16'h8002,16'h0000},
        '{1'b1,1'b1,1'b0,2'b01,16'h8004,16'h2222,2'd1,2'd1,1'b0,16'h8004,16'h2222},
        '{1'b1,1'b1,1'b1,2'b10,16'h8006,16'h3333,2'd1,2'd1,1'b0,16'h8006,16'h3333},
        '{1'b1,1'b0,1'b0,2'b11,16'h9000,16'hBEEF,2'd2,2'd2,1'b0,16'h9001,16'h90BE},
        '{1'b1,1'b0,1'b0,2'b10,16'h9010,16'h1234,2'd1,2'd1,1'b0,16'h9011,16'h9012},
        '{1'b1,1'b0,1'b1,2'b01,16'h9020,16'h0077,2'd1,2'd1,1'b0,16'h9020,16'h9077},
        '{1'b0,1'b1,1'b1,2'b11,16'h0400,16'h0000,2'd1,2'd1,1'b0,16'h0400,16'h5E3C},
        '{1'b0,1'b0,1'b1,2'b11,16'hA000,16'h0000,2'd2,2'd2,1'b0,16'hA001,16'h3D3C},
        '{1'b0,1'b1,1'b1,2'b11,16'h2100,16'h0000,2'd0,2'd0,1'b1,16'h0000,16'h0000},
        '{1'b0,1'b1,1'b1,2'b11,16'h1FFD,16'h0000,2'd0,2'd0,1'b1,16'h0000,16'h0000},
        '{1'b0,1'b1,1'b1,2'b11,16'h0100,16'h0000,2'd0,2'd0,1'b1,16'h0000,16'h0000},
        '{1'b0,1'b0,1'b1,2'b10,16'hB000,16'h0000,2'd1,2'd1,1'b0,16'hB001,16'h3D00},
        '{1'b1,1'b1,1'b0,2'b11,16'h8010,16'h4444,2'd1,2'd1,1'b0,16'h8010,16'h4444}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_tick = 1'b0;
    logic        ea_n = 1'b1;
    logic        cfg_strobe_sel = 1'b1;
    logic        cfg_bus16 = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_be = 2'b11;
    logic [15:0] req_wdata = '0;
    logic        rsp_done;
    logic        rsp_internal;
    logic [15:0] rsp_rdata;
    logic [15:0] ad_in;
    logic [15:0] ad_out;
    logic        ad_oe;
    logic        ale;
    logic        adv_n;
    logic        rd_n;
    logic        wrx_n;

    int checks = 0;
    int errors = 0;

    // monitor state, written only by the monitor process
    int          clk_cnt = 0;
    int          n_ale = 0;
    int          n_wr = 0;
    int          n_rd = 0;
    int          adv_bad = 0;
    int          last_rise = 0;
    int          last_gap = 0;
    logic [15:0] mon_addr = '0;
    logic [15:0] mon_wdat = '0;
    logic        p_ale = 1'b0;
    logic        p_wr = 1'b1;
    logic        p_rd = 1'b1;
    int          tcnt = 0;

    // snapshot of the response, taken by the request task
    logic        got_int;
    logic [15:0] got_rdata;
    logic        got_adv;
    logic        got_pulse_gone;

    assign ad_in = mon_addr ^ KEY;

    xbus_ctrl dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .st_tick       (st_tick),
        .ea_n          (ea_n),
        .cfg_strobe_sel(cfg_strobe_sel),
        .cfg_bus16     (cfg_bus16),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_be        (req_be),
        .req_wdata     (req_wdata),
        .rsp_done      (rsp_done),
        .rsp_internal  (rsp_internal),
        .rsp_rdata     (rsp_rdata),
        .ad_in         (ad_in),
        .ad_out        (ad_out),
        .ad_oe         (ad_oe),
        .ale           (ale),
        .adv_n         (adv_n),
        .rd_n          (rd_n),
        .wrx_n         (wrx_n)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) clk_cnt <= clk_cnt + 1;

    // state-time tick generator, changes away from the active edge
    always @(negedge clk) begin
        tcnt    <= (tcnt == TICK_DIV-1) ? 0 : tcnt + 1;
        st_tick <= (tcnt == TICK_DIV-1);
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (ale && !p_ale) begin
                n_ale     <= n_ale + 1;
                mon_addr  <= ad_out;
                last_gap  <= clk_cnt - last_rise;
                last_rise <= clk_cnt;
            end
            if (!wrx_n && p_wr) n_wr <= n_wr + 1;
            if (!wrx_n) mon_wdat <= ad_out;
            if (!rd_n && p_rd) n_rd <= n_rd + 1;
            if ((!rd_n || !wrx_n) && adv_n) adv_bad <= adv_bad + 1;
        end
        p_ale <= ale;
        p_wr  <= wrx_n;
        p_rd  <= rd_n;
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_req(input logic w, input logic b16, input logic ss,
                           input logic [1:0] be, input logic [15:0] a,
                           input logic [15:0] d);
        req_write      = w;
        cfg_bus16      = b16;
        cfg_strobe_sel = ss;
        req_be         = be;
        req_addr       = a;
        req_wdata      = d;
        req_valid      = 1'b1;
    endtask

    task automatic wait_done();
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!rsp_done && guard < 200);
        got_int   = rsp_internal;
        got_rdata = rsp_rdata;
        got_adv   = adv_n;
    endtask

    task automatic run_req(input logic w, input logic b16, input logic ss,
                           input logic [1:0] be, input logic [15:0] a,
                           input logic [15:0] d);
        @(negedge clk);
        set_req(w, b16, ss, be, a, d);
        wait_done();
        req_valid = 1'b0;
        @(negedge clk);
        got_pulse_gone = !rsp_done;
        repeat (5*TICK_DIV) @(negedge clk);
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 1'b0;
        ea_n  = strap;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(CLK_P*150000);
        errors++;
        $display("FAIL watchdog actual=hang expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int a0, w0, r0;
        do_reset(1'b1);

        // R10: reset state
        chk(ale == 1'b0, "R10 ale", ale, 0);
        chk(adv_n && rd_n && wrx_n, "R10 strobes high", {adv_n, rd_n, wrx_n}, 3'b111);
        chk(ad_oe == 1'b0, "R10 oe", ad_oe, 0);
        chk(rsp_done == 1'b0, "R10 done", rsp_done, 0);

        // table walk with strap inactive: R1 R3 R4 R5 R6 R9
        for (int i = 0; i < NV; i++) begin
            a0 = n_ale; w0 = n_wr; r0 = n_rd;
            run_req(TBL[i].wr, TBL[i].b16, TBL[i].ssel, TBL[i].be, TBL[i].addr, TBL[i].wd);
            chk(n_ale - a0 == int'(TBL[i].n_ale), $sformatf("R1 R6 vec%0d ale count", i),
                n_ale - a0, TBL[i].n_ale);
            chk(got_int == TBL[i].intl, $sformatf("R9 vec%0d routing", i),
                got_int, TBL[i].intl);
            chk(got_adv == 1'b1, $sformatf("R2 vec%0d adv at done", i), got_adv, 1);
            chk(got_pulse_gone, $sformatf("R10 vec%0d done one clock", i), 0, 1);
            if (TBL[i].wr) begin
                chk(n_wr - w0 == int'(TBL[i].n_str), $sformatf("R4 vec%0d strobe count", i),
                    n_wr - w0, TBL[i].n_str);
                chk(n_rd == r0, $sformatf("R3 vec%0d no read strobe", i), n_rd - r0, 0);
                if (TBL[i].n_str != 0)
                    chk(mon_wdat == TBL[i].e_val, $sformatf("R5 R6 vec%0d write data", i),
                        mon_wdat, TBL[i].e_val);
            end else begin
                chk(n_rd - r0 == int'(TBL[i].n_str), $sformatf("R3 vec%0d read count", i),
                    n_rd - r0, TBL[i].n_str);
                chk(n_wr == w0, $sformatf("R4 vec%0d no write strobe", i), n_wr - w0, 0);
                if (!TBL[i].intl)
                    chk(got_rdata == TBL[i].e_val, $sformatf("R3 R6 vec%0d read data", i),
                        got_rdata, TBL[i].e_val);
            end
            if (TBL[i].n_ale != 0)
                chk(mon_addr == TBL[i].e_addr, $sformatf("R1 R6 vec%0d address", i),
                    mon_addr, TBL[i].e_addr);
            if (TBL[i].n_ale == 2)
                chk(last_gap == 4*TICK_DIV, $sformatf("R7 vec%0d split gap", i),
                    last_gap, 4*TICK_DIV);
        end

        // R9: boundary just below the always-external window
        a0 = n_ale;
        run_req(1'b0, 1'b1, 1'b1, 2'b11, 16'h02FF, 16'h0);
        chk(got_int == 1'b1 && n_ale == a0, "R9 02FF internal", got_int, 1);
        run_req(1'b0, 1'b1, 1'b1, 2'b11, 16'h0300, 16'h0);
        chk(got_int == 1'b0 && got_rdata == 16'h593C, "R9 0300 external", got_rdata, 16'h593C);

        // R7: new request presented right after done
        @(negedge clk);
        set_req(1'b0, 1'b1, 1'b1, 2'b11, 16'h8100, 16'h0);
        wait_done();
        set_req(1'b0, 1'b1, 1'b1, 2'b11, 16'h8200, 16'h0);
        wait_done();
        req_valid = 1'b0;
        chk(last_gap == 4*TICK_DIV, "R7 back-to-back gap", last_gap, 4*TICK_DIV);
        chk(got_rdata == (16'h8200 ^ KEY), "R7 second read data", got_rdata, 16'h8200 ^ KEY);
        repeat (5*TICK_DIV) @(negedge clk);

        // R8 R9: strap active
        do_reset(1'b0);
        run_req(1'b0, 1'b1, 1'b1, 2'b11, 16'h2100, 16'h0);
        chk(got_int == 1'b0 && got_rdata == 16'h7B3C, "R9 2100 external with strap",
            got_rdata, 16'h7B3C);
        run_req(1'b0, 1'b1, 1'b1, 2'b11, 16'h1FFE, 16'h0);
        chk(got_int == 1'b0 && got_rdata == 16'h45C2, "R9 1FFE external with strap",
            got_rdata, 16'h45C2);
        a0 = n_ale;
        run_req(1'b0, 1'b1, 1'b1, 2'b11, 16'h1FFB, 16'h0);
        chk(got_int == 1'b1 && n_ale == a0, "R9 1FFB internal with strap", got_int, 1);

        // R8: changing the strap after reset has no effect
        ea_n = 1'b1;
        repeat (3) @(negedge clk);
        run_req(1'b0, 1'b1, 1'b1, 2'b11, 16'h2100, 16'h0);
        chk(got_int == 1'b0 && got_rdata == 16'h7B3C, "R8 strap held after release",
            got_int, 0);

        chk(adv_bad == 0, "R2 adv low under strobes", adv_bad, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule